// File: doc/BRIEF.md
# Automatic Online Power Controller

This block decides when the line drivers and charge pump of a two-receiver serial line transceiver are powered. It takes a shutdown pin, a force-online pin, a receiver output-disable pin and one digitized "line at a valid level" flag for each receiver. It drives a pump/driver enable, a receiver output enable, a link status output and a flag that reports when the supply rails are ready.

In automatic mode the controller watches all receivers. Once every receiver has shown no valid level for an accumulated idle window, it powers the drivers down into standby. Activity on any one receiver powers them up again. The shutdown pin overrides everything. The force-online pin bypasses the idle logic. The receivers themselves keep running in every mode, so their output enable depends only on the output-disable pin.

All pins are synchronized by two flops before use. Both the idle window and the rail settling time are given in microseconds and converted to cycle counts from a clock-frequency parameter.

Top module: `auto_online_ctrl`

## Requirements
- R1: While `shdn_n` is low, `pump_en` and `rails_ok` are low three clock edges after the pin falls, whatever `force_on` and `rx_valid` are.
- R2: With `shdn_n` high and `force_on` high, `pump_en` is high three edges later and stays high while no receiver is active.
- R3: In automatic mode (`shdn_n` high, `force_on` low), after all `rx_valid` bits go low, `pump_en` stays high through edge IDLE_CYC+1 and is low at edge IDLE_CYC+2, where IDLE_CYC = IDLE_US x CLK_HZ / 1e6.
- R4: Any single receiver showing a valid level during the idle window restarts it, so that the IDLE_CYC+2 edge count starts again from the last falling activity.
- R5: From standby, a valid level on any one receiver raises `pump_en` three edges after the input changes.
- R6: `link_up` is high three edges after `shdn_n` is high and at least one `rx_valid` bit is high. It is low three edges after every receiver goes idle or `shdn_n` falls.
- R7: `rx_out_en` is the inverse of `rx_hiz` two edges after that pin changes, in every power mode including shutdown.
- R8: `rails_ok` rises RAIL_CYC+3 edges after the input change that raises `pump_en` (RAIL_CYC = RAIL_US x CLK_HZ / 1e6), and it is low whenever `pump_en` is low.
- R9: During reset `pump_en`, `link_up`, `rails_ok` and `rx_out_en` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_n | input | 1 | Low forces shutdown |
| force_on | input | 1 | High keeps drivers on and bypasses the idle logic |
| rx_hiz | input | 1 | High disables the receiver outputs |
| rx_valid | input | NUM_RX | Per-receiver flag that the line is at a valid level |
| pump_en | output | 1 | Enables the drivers and the charge pump |
| rx_out_en | output | 1 | Receiver output enable |
| link_up | output | 1 | Far-end activity present and not shut down |
| rails_ok | output | 1 | Supply rails settled after power-up |

## Verification
The bench builds the controller with CLK_HZ set to 1 MHz, which gives an idle window of 20 cycles and a rail settling time of 200 cycles. It keeps NUM_RX at 2. With these small counts, the exact edges where standby is entered, the window is restarted and the rails become ready can all be reached and checked on both sides in a short run. Having two receivers shows that one active line alone is enough both to wake the block and to hold it awake.

// File: rtl/auto_online_ctrl.sv
module auto_online_ctrl #(
  parameter int CLK_HZ  = 125_000_000,
  parameter int NUM_RX  = 2,
  parameter int IDLE_US = 20,
  parameter int RAIL_US = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shdn_n,
  input  logic              force_on,
  input  logic              rx_hiz,
  input  logic [NUM_RX-1:0] rx_valid,
  output logic              pump_en,
  output logic              rx_out_en,
  output logic              link_up,
  output logic              rails_ok
);
  localparam int PER_US   = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
  localparam int IDLE_CYC = (PER_US * IDLE_US < 1) ? 1 : PER_US * IDLE_US;
  localparam int RAIL_CYC = (PER_US * RAIL_US < 1) ? 1 : PER_US * RAIL_US;
  localparam int IW = $clog2(IDLE_CYC + 1);
  localparam int RW = $clog2(RAIL_CYC + 1);
  localparam int SW = NUM_RX + 3;
  localparam logic [SW-1:0] SYNC_RST = {1'b1, {(SW-1){1'b0}}};

  logic [SW-1:0] meta, sync;
  logic hiz_s, force_s, shdn_s, any_act, auto_m, idle_done;
  logic [NUM_RX-1:0] valid_s;
  logic [IW-1:0] idle_cnt;
  logic [RW-1:0] rail_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= SYNC_RST;
      sync <= SYNC_RST;
    end else begin
      meta <= {rx_hiz, force_on, shdn_n, rx_valid};
      sync <= meta;
    end
  end

  assign hiz_s     = sync[SW-1];
  assign force_s   = sync[SW-2];
  assign shdn_s    = sync[SW-3];
  assign valid_s   = sync[NUM_RX-1:0];
  assign any_act   = |valid_s;
  assign auto_m    = shdn_s & ~force_s;
  assign idle_done = (idle_cnt == IW'(IDLE_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pump_en  <= 1'b0;
      idle_cnt <= '0;
      link_up  <= 1'b0;
    end else begin
      link_up <= shdn_s & any_act;
      if (!shdn_s) begin
        pump_en  <= 1'b0;
        idle_cnt <= '0;
      end else if (force_s || any_act) begin
        pump_en  <= 1'b1;
        idle_cnt <= '0;
      end else if (pump_en) begin
        if (idle_done) begin
          pump_en  <= 1'b0;
          idle_cnt <= '0;
        end else begin
          idle_cnt <= idle_cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      rail_cnt <= '0;
    else if (!pump_en)               rail_cnt <= '0;
    else if (rail_cnt != RW'(RAIL_CYC)) rail_cnt <= rail_cnt + 1'b1;
  end

  assign rails_ok  = pump_en && (rail_cnt == RW'(RAIL_CYC));
  assign rx_out_en = ~hiz_s;
endmodule

// File: rtl/auto_online_chk.sv
module auto_online_chk #(
  parameter int NUM_RX = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              shdn_s,
  input logic              force_s,
  input logic [NUM_RX-1:0] valid_s,
  input logic              pump_en,
  input logic              link_up,
  input logic              rails_ok
);
  AST_SHDN_OFF: assert property (@(posedge clk) disable iff (!rst_n) !shdn_s |=> !pump_en); // R1
  AST_FORCE_ON: assert property (@(posedge clk) disable iff (!rst_n) (shdn_s && force_s) |=> pump_en); // R2
  AST_IDLE_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(pump_en) |-> ($past(!shdn_s) || $past(valid_s) == '0)); // R3
  AST_WAKE: assert property (@(posedge clk) disable iff (!rst_n) (shdn_s && valid_s != '0) |=> pump_en); // R5
  AST_LINK_SHDN: assert property (@(posedge clk) disable iff (!rst_n) !shdn_s |=> !link_up); // R6
  AST_READY_PUMP: assert property (@(posedge clk) disable iff (!rst_n) rails_ok |-> pump_en); // R8
  AST_READY_LATE: assert property (@(posedge clk) disable iff (!rst_n) $rose(pump_en) |-> !rails_ok); // R8
endmodule

bind auto_online_ctrl auto_online_chk #(.NUM_RX(NUM_RX)) u_chk (
  .clk(clk), .rst_n(rst_n), .shdn_s(shdn_s), .force_s(force_s), .valid_s(valid_s),
  .pump_en(pump_en), .link_up(link_up), .rails_ok(rails_ok)
);

// File: tb/sim_auto_online_ctrl.sv
`timescale 1ns/1ps
module sim_auto_online_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic shdn_n = 1'b0, force_on = 1'b0, rx_hiz = 1'b0;
  logic [1:0] rx_valid = 2'b00;
  logic pump_en, rx_out_en, link_up, rails_ok;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  auto_online_ctrl #(.CLK_HZ(1_000_000), .NUM_RX(2), .IDLE_US(20), .RAIL_US(200)) u0 (
    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .force_on(force_on), .rx_hiz(rx_hiz),
    .rx_valid(rx_valid), .pump_en(pump_en), .rx_out_en(rx_out_en), .link_up(link_up),
    .rails_ok(rails_ok)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    #20;
    chk("R9 pump_en", pump_en, 1'b0);
    chk("R9 link_up", link_up, 1'b0);
    chk("R9 rails_ok", rails_ok, 1'b0);
    chk("R9 rx_out_en", rx_out_en, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    edges(1);
  endtask

  task automatic t_wake();
    shdn_n = 1'b1; rx_valid = 2'b11;
    edges(2);
    chk("R5 pump before sync", pump_en, 1'b0);
    chk("R7 rx_out_en", rx_out_en, 1'b1);
    edges(1);
    chk("R5 pump woken", pump_en, 1'b1);
    chk("R6 link_up active", link_up, 1'b1);
    chk("R8 rails not yet", rails_ok, 1'b0);
  endtask

  task automatic t_rails();
    edges(199);
    chk("R8 rails at edge 202", rails_ok, 1'b0);
    edges(1);
    chk("R8 rails at edge 203", rails_ok, 1'b1);
  endtask

  task automatic t_standby();
    rx_valid = 2'b00;
    edges(3);
    chk("R6 link_up idle", link_up, 1'b0);
    edges(18);
    chk("R3 pump at edge 21", pump_en, 1'b1);
    edges(1);
    chk("R3 pump at edge 22", pump_en, 1'b0);
    chk("R8 rails drop", rails_ok, 1'b0);
  endtask

  task automatic t_window();
    rx_valid = 2'b01;
    edges(3);
    chk("R5 one receiver wakes", pump_en, 1'b1);
    rx_valid = 2'b00;
    edges(12);
    rx_valid = 2'b10;
    edges(1);
    rx_valid = 2'b00;
    edges(21);
    chk("R4 window restarted", pump_en, 1'b1);
    edges(1);
    chk("R4 standby after restart", pump_en, 1'b0);
  endtask

  task automatic t_force();
    force_on = 1'b1;
    edges(50);
    chk("R2 forced on", pump_en, 1'b1);
    chk("R6 no activity", link_up, 1'b0);
    force_on = 1'b0;
    edges(22);
    chk("R3 auto after force", pump_en, 1'b0);
  endtask

  task automatic t_shutdown();
    rx_valid = 2'b11; force_on = 1'b1; shdn_n = 1'b0; rx_hiz = 1'b1;
    edges(2);
    chk("R7 hiz in shutdown", rx_out_en, 1'b0);
    edges(1);
    chk("R1 pump off", pump_en, 1'b0);
    chk("R1 rails off", rails_ok, 1'b0);
    chk("R6 link_up shutdown", link_up, 1'b0);
    rx_hiz = 1'b0;
    edges(2);
    chk("R7 receivers on in shutdown", rx_out_en, 1'b1);
    edges(100);
    chk("R1 pump stays off", pump_en, 1'b0);
  endtask

  initial begin
    t_reset();
    t_wake();
    t_rails();
    t_standby();
    t_window();
    t_force();
    t_shutdown();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule